// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target end of a two-wire serial memory bus, placed in front of a small byte-wide array. The array is modelled here as on-chip SRAM. A bus master addresses the block with a select byte. It then writes one byte or a run of bytes inside one page, or it reads back from the current pointer, from an address it has just loaded, or as a stream that continues through the array. SCL and SDA come in as plain inputs and pass through a synchroniser into the system clock. The block answers on SDA through a drive-low enable, so outside logic can build the open-drain pad.

The size parameter `MEM_KBIT` takes the values 1, 2, 4, 8 or 16. It sets the array depth, the page length and how the three middle select bits are split between chip-select compares and upper address bits. A write ends at STOP, which starts a programming interval of `PROG_CYCLES` system clocks. During that interval the block stays silent, so a master can poll for completion. A write-protect input blocks stores.

The control is one state machine. ST_IDLE waits for START. ST_SELECT shifts in the select byte and leaves either to ST_SELECT_ACK (match) or back to ST_IDLE (no match). From ST_SELECT_ACK the machine goes to ST_WADDR for a write or to ST_RDATA for a read. ST_WADDR goes to ST_WADDR_ACK and then to ST_WDATA. ST_WDATA and ST_WDATA_ACK alternate for each data byte. ST_RDATA goes to ST_RACK. From ST_RACK the machine returns to ST_RDATA on a master ACK or falls to ST_IDLE on a NACK. A START in any state jumps to ST_SELECT, and a STOP in any state jumps to ST_IDLE.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the block ignores the bus until a START, which is SDA falling while SCL is high. Bytes clocked without a START get no ACK, and neither does anything after an unmatched select byte until the next START.
- R2: The select byte is sent MSB first. Bits 7:4 must be 1010 and bit 0 is R/W, with 1 meaning read. Each of select bits 3:1 that is a chip select must equal `cs_pins_i` bit k-1 for select bit k. On a match the block pulls SDA low for the whole ninth clock. Otherwise it gives no ACK.
- R3: The block-address bits are: none at 1 and 2 Kbit, select bit 1 at 4 Kbit, bits 2:1 at 8 Kbit and bits 3:1 at 16 Kbit. They form the upper bits of the word address, so two addresses with the same low byte but different block bits hold separate data.
- R4: A byte write consists of a select byte with R/W=0, a word-address byte and a data byte, each of which is ACKed. The data byte is stored at that address.
- R5: In a page write, the low address bits (3 bits at 1 and 2 Kbit, 4 bits otherwise) step by one after each data byte and wrap inside the page. The upper bits stay unchanged.
- R6: A STOP that follows at least one stored byte starts a programming interval of `PROG_CYCLES` clocks. During that interval no select byte is ACKed. After it, select bytes are ACKed again.
- R7: Random read: a select byte with R/W=0, then a word address, a repeated START and a select byte with R/W=1. The block then returns the byte at that address.
- R8: A read that begins with a select byte with R/W=1 returns the byte one past the last one accessed.
- R9: A master ACK after a read byte fetches the next address, and the address after the top of the array is 0. A master NACK ends the read and SDA is released.
- R10: With `wp_i` high, data bytes are still ACKed but are not stored, and they start no programming interval. The whole array is protected, except at 16 Kbit, where only the upper half is protected.
- R11: SDA is only ever pulled low: during a slave ACK, or during a read bit that is 0. The drive only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus (wired-AND line) |
| cs_pins_i | input | 3 | Chip-select strap values compared with select bits 3:1 |
| wp_i | input | 1 | Write protect, active high |
| sda_drive_low_o | output | 1 | When 1, the pad pulls SDA low |

## Verification
The assertions assume the bus follows the two-wire rules. SDA changes only while SCL is low, except at START and STOP, and the master never makes a START or STOP while the slave is holding SDA low. The hold check on SDA relies on this. They also assume each SCL phase lasts several system clocks, so every edge survives the synchroniser. The bench master keeps each SCL phase ten clocks long. It moves SDA five clocks after SCL falls and reads the line in the middle of the high phase. It begins START and STOP only after the slave has released the line.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SELECT_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } smem_state_t;

    // array address width for a given size in Kbit
    function automatic int addr_bits(input int kbit);
        case (kbit)
            1:       return 7;
            2:       return 8;
            4:       return 9;
            8:       return 10;
            default: return 11;
        endcase
    endfunction

    // number of select bits that carry upper address bits
    function automatic int block_bits(input int kbit);
        if (kbit <= 2) return 0;
        if (kbit == 4) return 1;
        if (kbit == 8) return 2;
        return 3;
    endfunction

    // page index width: 8-byte pages for small sizes, 16-byte otherwise
    function automatic int page_bits(input int kbit);
        return (kbit <= 2) ? 3 : 4;
    endfunction

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES synchronising flops plus one history flop per line
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_prev, sda_prev;
    assign scl_lvl  = scl_pipe[STAGES-1];
    assign sda_lvl  = sda_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_prev = sda_pipe[STAGES];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smem_prog_timer.sv
module smem_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (start)
            remain_q <= CW'(CYCLES);
        else if (remain_q != '0)
            remain_q <= remain_q - CW'(1);
    end

    assign busy = (remain_q != '0);

    // R6
    prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/smem_byte_ram.sv
module smem_byte_ram #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import smem_pkg::*;
#(
    parameter int MEM_KBIT    = 4,
    parameter int PROG_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] cs_pins_i,
    input  logic       wp_i,
    output logic       sda_drive_low_o
);
    localparam int AW     = addr_bits(MEM_KBIT);
    localparam int NB     = block_bits(MEM_KBIT);
    localparam int PAGE_W = page_bits(MEM_KBIT);
    localparam logic [2:0] CS_MASK = 3'(3'b111 << NB);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, prog_start;
    logic mem_we, prot, sel_ok, byte_done;
    logic [7:0] rdata;

    smem_state_t   state_q, state_d;
    logic [7:0]    shreg_q;
    logic [3:0]    cnt_q;
    logic [2:0]    blk_q;
    logic [AW-1:0] ptr_q;
    logic          mack_q;
    logic          wr_pend_q;

    smem_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smem_prog_timer #(.CYCLES(PROG_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    smem_byte_ram #(.AW(AW)) ram_i (
        .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(shreg_q),
        .raddr(ptr_q), .rdata(rdata)
    );

    assign byte_done  = scl_fall && (cnt_q == 4'd8);
    assign sel_ok     = (shreg_q[7:4] == 4'b1010)
                     && (((shreg_q[3:1] ^ cs_pins_i) & CS_MASK) == 3'b000)
                     && !busy;
    assign prot       = wp_i && ((MEM_KBIT != 16) || ptr_q[AW-1]);
    assign mem_we     = (state_q == ST_WDATA) && byte_done && !prot
                     && !start_det && !stop_det;
    assign prog_start = stop_det && wr_pend_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_SELECT;
        else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_SELECT:     if (byte_done) state_d = sel_ok ? ST_SELECT_ACK : ST_IDLE;
                ST_SELECT_ACK: if (scl_fall)  state_d = shreg_q[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:      if (byte_done) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK:  if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:      if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK:  if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:      if (scl_fall && cnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK:       if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IDLE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            cnt_q     <= '0;
            blk_q     <= '0;
            ptr_q     <= '0;
            mack_q    <= 1'b0;
            wr_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (stop_det)
                wr_pend_q <= 1'b0;
            else if (mem_we)
                wr_pend_q <= 1'b1;

            if (start_det || stop_det) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_SELECT, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[6:0], sda_lvl};
                            cnt_q   <= cnt_q + 4'd1;
                        end else if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == ST_SELECT && sel_ok)
                                blk_q <= shreg_q[3:1];
                            if (state_q == ST_WADDR)
                                ptr_q <= AW'({blk_q, shreg_q});
                            if (state_q == ST_WDATA)
                                ptr_q <= {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                    end
                    ST_SELECT_ACK: begin
                        if (scl_fall && shreg_q[0]) begin
                            shreg_q <= rdata;
                            ptr_q   <= ptr_q + AW'(1);
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                cnt_q <= '0;
                            end else begin
                                shreg_q <= {shreg_q[6:0], 1'b0};
                                cnt_q   <= cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)
                            mack_q <= !sda_lvl;
                        else if (scl_fall && mack_q) begin
                            shreg_q <= rdata;
                            ptr_q   <= ptr_q + AW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // output logic
    always_comb begin
        sda_drive_low_o = 1'b0;
        unique case (state_q)
            ST_SELECT_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_drive_low_o = 1'b1;
            ST_RDATA: sda_drive_low_o = !shreg_q[7];
            default:  sda_drive_low_o = 1'b0;
        endcase
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_det) |=> (state_q == ST_IDLE));

    // R6
    prog_busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELECT_ACK) |-> !busy);

    // R10
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_i && MEM_KBIT != 16) |-> !mem_we);

    // R11
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_drive_low_o));

endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int PROG       = 600;
    localparam int WATCHDOG   = 150000;
    localparam logic [2:0] CS = 3'b101;

    typedef struct packed {
        logic       wp;
        logic [8:0] addr;
        logic [7:0] data;
        logic [7:0] expv;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 9'h005, 8'hA5, 8'hA5},
        '{1'b0, 9'h1F0, 8'h3C, 8'h3C},
        '{1'b0, 9'h0F0, 8'h11, 8'h11},
        '{1'b1, 9'h005, 8'hFF, 8'hA5},
        '{1'b0, 9'h1FF, 8'h80, 8'h80},
        '{1'b0, 9'h000, 8'h7E, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic drv;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_mem_slave #(.MEM_KBIT(4), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .cs_pins_i(CS), .wp_i(wp), .sda_drive_low_o(drv)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = !b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic master_ack);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(!master_ack);
    endtask

    function automatic logic [7:0] sel(input logic [8:0] a, input logic rd);
        return {4'b1010, CS[2:1], a[8], rd};
    endfunction

    task automatic read_begin(input logic [8:0] a);
        logic ack;
        bus_start; put_byte(sel(a, 1'b0), ack); put_byte(a[7:0], ack);
        bus_start; put_byte(sel(a, 1'b1), ack);
    endtask

    task automatic poll_ready(output int tries);
        logic ack;
        tries = 0;
        for (int k = 0; k < 60; k++) begin
            bus_start; put_byte(sel(9'h0, 1'b0), ack); bus_stop;
            tries++;
            if (ack) break;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int tries;
        string tag;

        tick(4);
        // R11: released during reset and after it
        check(drv == 1'b0, "R11", drv, 0);
        rst_n = 1'b1;
        tick(4);
        check(drv == 1'b0, "R11", drv, 0);

        // R1: a valid select byte without START draws no ACK
        scl_m = 1'b0; tick(Q);
        put_byte(sel(9'h0, 1'b0), ack);
        check(ack == 1'b0, "R1", ack, 0);
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);

        // R2: chip-select mismatch, bad prefix, then a match
        bus_start; put_byte(8'hAC, ack); bus_stop;
        check(ack == 1'b0, "R2", ack, 0);
        bus_start; put_byte(8'hB8, ack); bus_stop;
        check(ack == 1'b0, "R2", ack, 0);
        bus_start; put_byte(sel(9'h0, 1'b0), ack); bus_stop;
        check(ack == 1'b1, "R2", ack, 1);

        // table of single-byte writes, each read back at random
        for (int i = 0; i < 6; i++) begin
            tag = VEC[i].wp ? "R10" : (VEC[i].addr[8] ? "R3" : "R4");
            wp = VEC[i].wp;
            bus_start;
            put_byte(sel(VEC[i].addr, 1'b0), ack);
            check(ack == 1'b1, "R4", ack, 1);
            put_byte(VEC[i].addr[7:0], ack);
            put_byte(VEC[i].data, ack);
            check(ack == 1'b1, tag, ack, 1);
            bus_stop;
            // R6 / R10: silent while programming, answered when protected
            bus_start; put_byte(sel(9'h0, 1'b0), ack); bus_stop;
            check(ack == VEC[i].wp, VEC[i].wp ? "R10" : "R6", ack, VEC[i].wp);
            wp = 1'b0;
            poll_ready(tries);
            check(tries < 60, "R6", tries, 60);
            read_begin(VEC[i].addr);
            get_byte(d, 1'b0);
            bus_stop;
            check(d == VEC[i].expv, tag, d, VEC[i].expv);
        end

        // R3: upper block untouched by the same low byte in the lower block
        read_begin(9'h1F0); get_byte(d, 1'b0); bus_stop;
        check(d == 8'h3C, "R3", d, 8'h3C);

        // R5: six bytes from 0x13C wrap inside the 16-byte page
        bus_start; put_byte(sel(9'h13C, 1'b0), ack); put_byte(8'h3C, ack);
        for (int i = 0; i < 6; i++) put_byte(8'hC0 + 8'(i), ack);
        bus_stop;
        poll_ready(tries);
        read_begin(9'h130);
        get_byte(d, 1'b1);
        check(d == 8'hC4, "R5", d, 8'hC4);
        get_byte(d, 1'b0);
        bus_stop;
        check(d == 8'hC5, "R5", d, 8'hC5);

        // R7: random read, then R8: current-address read continues
        read_begin(9'h13C); get_byte(d, 1'b0); bus_stop;
        check(d == 8'hC0, "R7", d, 8'hC0);
        bus_start; put_byte(sel(9'h13D, 1'b1), ack);
        get_byte(d, 1'b0); bus_stop;
        check(d == 8'hC1, "R8", d, 8'hC1);

        // R9: sequential read wraps from the top address to 0
        read_begin(9'h1FF);
        get_byte(d, 1'b1);
        check(d == 8'h80, "R9", d, 8'h80);
        get_byte(d, 1'b0);
        check(d == 8'h7E, "R9", d, 8'h7E);
        bus_stop;
        tick(4);
        check(drv == 1'b0, "R9", drv, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule